// File: doc/BRIEF.md
# Flyback Controller Fault Supervisor

This block sits between the PWM core of a quasi-resonant flyback controller and its gate driver. It accepts the digitized outputs of the protection comparators: abnormal overcurrent, VCC overvoltage, over-temperature, the VCC-on and VCC-reset levels, line removal, and the zero-crossing arming level. It also accepts the PWM drive request. From these it forms the gate-drive output, an enable for the valley-timeout timer, and a two-bit operating state.

Each drive pulse begins on a rising edge of the request. The pulse is capped at a maximum on-time. The abnormal-overcurrent comparator is ignored during a short blanking window after turn-on. Once the window has passed, a trip ends the pulse. Trips are counted across consecutive pulses, and a run of them forces a latched shutdown. Overvoltage also forces the latched shutdown, and its effect on the gate is immediate. Over-temperature leads to a non-latching stop, which restarts on a later VCC-on.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, `state_o` reads 3 (waiting for VCC-on) and `drv_o` is 0. The state codes are: 0 running, 1 latched fault, 2 auto-restart fault, 3 waiting for VCC-on.
- R2: In state 3, the block moves to state 0 one clock after `vcc_on_i` is high while `otp_i`, `ovp_i`, `line_lost_i` and `vcc_rst_i` are all low. Otherwise it remains in state 3.
- R3: A drive pulse starts one clock after a rising edge of `drv_req_i` in state 0. During the first `BLANK_CYC` cycles of the pulse, `aoc_i` is ignored. If `aoc_i` is held high from the start, the pulse lasts exactly `BLANK_CYC`+1 cycles.
- R4: `AOC_HITS` consecutive pulses that are each ended by `aoc_i` put the block in state 1.
- R5: A pulse that ends without an `aoc_i` trip clears the count of consecutive trips.
- R6: No pulse lasts longer than `TON_MAX_CYC` cycles, even while `drv_req_i` stays high. A new pulse needs the request to fall and rise again.
- R7: State 1 is left only through `vcc_rst_i`, which leads to state 3. In state 1, `drv_o` stays 0.
- R8: While `ovp_i` is high, `drv_o` is 0 in the same cycle. In state 0, `ovp_i` leads to state 1 on the next clock.
- R9: In state 0, `otp_i` leads to state 2. State 2 returns to state 0 once `vcc_on_i` is high with `otp_i` low.
- R10: In state 0 or state 2, `vcc_rst_i` or `line_lost_i` leads to state 3. These two inputs take priority over every other fault.
- R11: `vto_en_o` is high only in state 0, with no pulse active and `zcd_armed_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_req_i | input | 1 | Drive request from the PWM core |
| aoc_i | input | 1 | Abnormal-overcurrent comparator output |
| ovp_i | input | 1 | VCC overvoltage comparator output |
| otp_i | input | 1 | Over-temperature flag |
| vcc_on_i | input | 1 | VCC above its start level |
| vcc_rst_i | input | 1 | VCC below its reset level |
| line_lost_i | input | 1 | Line removal detected |
| zcd_armed_i | input | 1 | Zero-crossing input above its arming level |
| drv_o | output | 1 | Gate-drive output |
| vto_en_o | output | 1 | Enable for the valley-timeout timer |
| state_o | output | 2 | Operating state: 0 run, 1 latched, 2 auto-restart, 3 wait |

## Verification
The bench drives `aoc_i` high from the very first cycle of each pulse and checks the exact pulse width. A design that does not blank would end the pulse at once, and a design with an off-by-one window would be one cycle off. It places a clean pulse between two runs of three trips: a counter that never clears would latch there, and a counter that clears on every pulse would never latch. It holds the request high well past the maximum on-time, which catches both a missing cap and a pulse that re-arms while the request stays high. It also raises overvoltage in the middle of a pulse, where a registered gate would stay high for one extra cycle.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_LATCH   = 2'd1,
    ST_RESTART = 2'd2,
    ST_WAIT    = 2'd3
  } fsup_state_e;
endpackage

// File: rtl/fsup_pulse.sv
module fsup_pulse #(
  parameter int BLANK_CYC   = 13,
  parameter int TON_MAX_CYC = 3200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_next_i,
  input  logic req_i,
  input  logic aoc_i,
  output logic on_o,
  output logic hit_o,
  output logic end_o
);
  localparam int CNT_W = $clog2(TON_MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(TON_MAX_CYC - 1);

  logic on_q, on_d, req_q, blank_done, max_hit;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (BLANK_CYC == 0) begin : g_no_blank
      assign blank_done = 1'b1;
    end else begin : g_blank
      localparam logic [CNT_W-1:0] BLANK_L = CNT_W'(BLANK_CYC);
      assign blank_done = (cnt_q >= BLANK_L);
    end
  endgenerate

  assign hit_o   = on_q & blank_done & aoc_i;
  assign max_hit = on_q & (cnt_q == LAST_L);

  always_comb begin
    if (!run_next_i)  on_d = 1'b0;
    else if (on_q)    on_d = req_i & ~hit_o & ~max_hit;
    else              on_d = req_i & ~req_q;  // rising edge only
  end

  assign end_o = on_q & ~on_d;
  assign on_o  = on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      req_q <= req_i;
      cnt_q <= (on_q & on_d) ? cnt_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/fsup_hit_cnt.sv
module fsup_hit_cnt #(
  parameter int AOC_HITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hit_i,
  input  logic end_i,
  output logic last_o
);
  localparam int HW = $clog2(AOC_HITS + 1);
  localparam logic [HW-1:0] LAST_L = HW'(AOC_HITS - 1);

  logic [HW-1:0] hits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hits_q <= '0;
    else if (!run_i)   hits_q <= '0;
    else if (hit_i)    hits_q <= hits_q + 1'b1;
    else if (end_i)    hits_q <= '0;  // clean pulse
  end

  assign last_o = (hits_q == LAST_L);
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vcc_on_i,
  input  logic        vcc_rst_i,
  input  logic        line_lost_i,
  input  logic        ovp_i,
  input  logic        otp_i,
  input  logic        hit_i,
  input  logic        last_i,
  output fsup_state_e state_o,
  output logic        run_next_o
);
  fsup_state_e st_q, st_d;
  logic start_ok;

  assign start_ok = vcc_on_i & ~otp_i & ~ovp_i & ~line_lost_i & ~vcc_rst_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (vcc_rst_i | line_lost_i) st_d = ST_WAIT;
        else if (ovp_i)              st_d = ST_LATCH;
        else if (hit_i & last_i)     st_d = ST_LATCH;
        else if (otp_i)              st_d = ST_RESTART;
      end
      ST_LATCH:   if (vcc_rst_i) st_d = ST_WAIT;
      ST_RESTART: begin
        if (vcc_rst_i | line_lost_i) st_d = ST_WAIT;
        else if (start_ok)           st_d = ST_RUN;
      end
      ST_WAIT:    if (start_ok) st_d = ST_RUN;
      default:    st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WAIT;
    else         st_q <= st_d;
  end

  assign state_o    = st_q;
  assign run_next_o = (st_d == ST_RUN);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int BLANK_CYC   = 13,
  parameter int TON_MAX_CYC = 3200000,
  parameter int AOC_HITS    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       drv_req_i,
  input  logic       aoc_i,
  input  logic       ovp_i,
  input  logic       otp_i,
  input  logic       vcc_on_i,
  input  logic       vcc_rst_i,
  input  logic       line_lost_i,
  input  logic       zcd_armed_i,
  output logic       drv_o,
  output logic       vto_en_o,
  output logic [1:0] state_o
);
  fsup_state_e st;
  logic run_next, on, hit, pend, last;

  fsup_ctrl u_ctrl (
    .clk_i, .rst_ni, .vcc_on_i, .vcc_rst_i, .line_lost_i, .ovp_i, .otp_i,
    .hit_i(hit), .last_i(last), .state_o(st), .run_next_o(run_next)
  );

  fsup_pulse #(.BLANK_CYC(BLANK_CYC), .TON_MAX_CYC(TON_MAX_CYC)) u_pulse (
    .clk_i, .rst_ni, .run_next_i(run_next), .req_i(drv_req_i), .aoc_i,
    .on_o(on), .hit_o(hit), .end_o(pend)
  );

  fsup_hit_cnt #(.AOC_HITS(AOC_HITS)) u_hits (
    .clk_i, .rst_ni, .run_i(st == ST_RUN), .hit_i(hit), .end_i(pend), .last_o(last)
  );

  assign drv_o    = on & ~ovp_i;  // overvoltage cuts the gate without a clock
  assign vto_en_o = (st == ST_RUN) & ~on & ~zcd_armed_i;
  assign state_o  = st;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int TON_MAX_CYC = 3200000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ovp_i,
  input logic       vcc_rst_i,
  input logic       vcc_on_i,
  input logic       zcd_armed_i,
  input logic       drv_o,
  input logic       vto_en_o,
  input logic [1:0] state_o
);
  int run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else         run_q <= drv_o ? run_q + 1 : 0;
  end

  AST_OVP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |-> !drv_o); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !vcc_rst_i) |=> (state_o == 2'd1)); // R7
  AST_LATCH_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> !drv_o); // R7
  AST_MAX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_o |-> (run_q < TON_MAX_CYC)); // R6
  AST_VTO_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zcd_armed_i |-> !vto_en_o); // R11
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && !vcc_on_i) |=> (state_o == 2'd3)); // R2
endmodule

bind fault_supervisor fsup_checker #(.TON_MAX_CYC(TON_MAX_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ovp_i(ovp_i), .vcc_rst_i(vcc_rst_i),
  .vcc_on_i(vcc_on_i), .zcd_armed_i(zcd_armed_i), .drv_o(drv_o),
  .vto_en_o(vto_en_o), .state_o(state_o)
);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
  localparam int BLANK = 13;
  localparam int TMAX  = 60;
  localparam int HITS  = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, aoc = 0, ovp = 0, otp = 0, von = 0, vrst = 0, line = 0, zcd = 0;
  logic drv, vto;
  logic [1:0] st;

  int errors = 0, checks = 0, cycles = 0, hi_cnt = 0;
  string tag = "R1";

  // reference model state
  int m_st = 3, m_cnt = 0, m_hits = 0;
  bit m_on = 0, m_rq = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.BLANK_CYC(BLANK), .TON_MAX_CYC(TMAX), .AOC_HITS(HITS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .drv_req_i(req), .aoc_i(aoc), .ovp_i(ovp),
    .otp_i(otp), .vcc_on_i(von), .vcc_rst_i(vrst), .line_lost_i(line),
    .zcd_armed_i(zcd), .drv_o(drv), .vto_en_o(vto), .state_o(st)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 3; m_on = 0; m_cnt = 0; m_hits = 0; m_rq = 0;
    end else begin
      bit hit, mx, nx_on, ok;
      int nst;
      hit = m_on && m_cnt >= BLANK && aoc;
      mx  = m_on && m_cnt == TMAX - 1;
      ok  = von && !otp && !ovp && !line && !vrst;
      nst = m_st;
      case (m_st)
        0: if (vrst || line) nst = 3; else if (ovp) nst = 1;
           else if (hit && m_hits == HITS - 1) nst = 1; else if (otp) nst = 2;
        1: if (vrst) nst = 3;
        2: if (vrst || line) nst = 3; else if (ok) nst = 0;
        default: if (ok) nst = 0;
      endcase
      if (nst != 0) nx_on = 0;
      else if (m_on) nx_on = req && !hit && !mx;
      else nx_on = req && !m_rq;
      if (m_st != 0) m_hits = 0;
      else if (hit) m_hits++;
      else if (m_on && !nx_on) m_hits = 0;
      m_cnt = (m_on && nx_on) ? m_cnt + 1 : 0;
      m_on = nx_on; m_rq = req; m_st = nst;
    end
  end

  task automatic chk(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      #1;
      chk(tag, int'(drv), int'(m_on && !ovp), "drv_o");
      chk(tag, int'(vto), int'(m_st == 0 && !m_on && !zcd), "vto_en_o");
      chk(tag, int'(st), m_st, "state_o");
      if (drv) hi_cnt++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(int hi, bit with_aoc);
    hi_cnt = 0; req = 1; aoc = with_aoc;
    cyc(hi);
    req = 0; aoc = 0;
    cyc(4);
  endtask

  task automatic power_up();
    von = 1; cyc(2); von = 0; cyc(1);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; cyc(1); chk("R1", int'(st), 3, "reset state"); chk("R1", int'(drv), 0, "reset drive");
    rst_ni = 1; cyc(3);
    tag = "R2"; chk("R2", int'(st), 3, "wait without vcc_on");
    otp = 1; von = 1; cyc(2); chk("R2", int'(st), 3, "otp blocks start");
    otp = 0; cyc(2); von = 0; chk("R2", int'(st), 0, "run after vcc_on");
    tag = "R11"; zcd = 1; cyc(2); chk("R11", int'(vto), 0, "zcd armed holds timer");
    zcd = 0; cyc(1); chk("R11", int'(vto), 1, "timer enabled when idle");
    tag = "R3"; pulse(20, 0); chk("R3", hi_cnt, 20, "clean pulse width");
    pulse(30, 1); chk("R3", hi_cnt, BLANK + 1, "blanked trip width");
    tag = "R5"; pulse(20, 0);
    repeat (3) pulse(30, 1);
    pulse(20, 0);
    repeat (3) pulse(30, 1);
    chk("R5", int'(st), 0, "clean pulse cleared count");
    tag = "R4"; pulse(30, 1); chk("R4", int'(st), 1, "latched after four trips");
    tag = "R7"; pulse(20, 0); chk("R7", hi_cnt, 0, "no drive while latched");
    von = 1; cyc(3); von = 0; chk("R7", int'(st), 1, "vcc_on cannot unlatch");
    vrst = 1; cyc(2); vrst = 0; chk("R7", int'(st), 3, "vcc reset unlatches");
    power_up();
    tag = "R6"; pulse(100, 0); chk("R6", hi_cnt, TMAX, "max on-time");
    tag = "R8"; req = 1; cyc(5); ovp = 1;
    #1; chk("R8", int'(drv), 0, "ovp same-cycle gate");
    cyc(1); ovp = 0; req = 0; cyc(1); chk("R8", int'(st), 1, "ovp latches");
    vrst = 1; cyc(1); vrst = 0; power_up();
    tag = "R9"; otp = 1; cyc(2); chk("R9", int'(st), 2, "otp auto-restart");
    pulse(10, 0); chk("R9", hi_cnt, 0, "no drive in restart");
    von = 1; cyc(3); chk("R9", int'(st), 2, "hot: no restart");
    otp = 0; cyc(2); von = 0; chk("R9", int'(st), 0, "restart on vcc_on");
    tag = "R10"; otp = 1; cyc(2); line = 1; otp = 0; cyc(2); line = 0;
    chk("R10", int'(st), 3, "line loss clears restart");
    power_up(); ovp = 1; line = 1; cyc(2); ovp = 0; line = 0;
    chk("R10", int'(st), 3, "line loss outranks ovp");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule